// File: doc/BRIEF.md
# Zone-Qualified Cache Coherency Sweeper

This block walks a set-associative data cache's tag array while the core keeps running. For every entry whose line address falls in a software-given zone and whose owner tag equals a given task identifier, it carries out one of three maintenance actions. *Invalidate* drops the line and discards its data. *Flush* pushes modified data out to memory and then drops the line. *Synchronize* pushes modified data out and keeps the line resident and clean.

Software starts a sweep with a single-cycle command pulse that carries the operation code, the zone bounds, the task identifier and the burst size. It then polls `busy`/`done` or waits for `irq`. The engine shares the tag port with normal core lookups and always yields to them. Modified data leaves through a valid/ready request port toward an external write-back buffer. Each request carries the address of an aligned group of fetch sets and the group's size.

Top module: `zone_sweep_engine`

## Requirements
- R1: Operation code 0 (invalidate) writes valid=0 and all dirty bits=0 into every matching entry and issues no write-back request.
- R2: Operation code 1 (flush) issues write-back requests for every matching entry that has a dirty fetch set, and afterwards writes valid=0 and dirty=0 into it. Matching clean entries are also invalidated.
- R3: Operation code 2 (synchronize) issues write-back requests for every matching dirty entry, then writes valid=1 and dirty=0 into it. Matching clean entries stay as they were.
- R4: An entry matches only when it is valid, its stored task field equals `cmd_task`, and its line address {tag, set index} lies within [`cmd_zone_lo`, `cmd_zone_hi`] inclusive. Every other entry is left unchanged.
- R5: Entries are visited with the set index as the outer ascending loop and the way as the inner ascending loop. Requests within one line go out in ascending fetch-set order, so the write-back stream follows this order.
- R6: A line's fetch sets form aligned groups of 2^`cmd_burst_log2` sets, and a value above log2(N_FS) means the whole line. One request goes out for each group that holds at least one dirty set, with `wb_addr` = {tag, index, first fetch set of the group} and `wb_len` = the group size. `wb_valid`, `wb_addr` and `wb_len` hold steady until `wb_ready`.
- R7: The engine never raises `tag_ce` in a cycle where `core_lookup` is high. When it is held off, it keeps the same entry and retries, and the result of the sweep is unchanged.
- R8: `busy` rises on the clock edge that accepts a command and falls on the edge that completes the sweep, and `done` sets on that same edge. `done` stays set until a cycle with `done_clr` high. If `done_clr` coincides with completion, `done` ends set.
- R9: A command while `busy`, or with operation code 3, is dropped and sets the sticky `err` flag, which `err_clr` clears. A running sweep is not affected.
- R10: `irq` equals `done` AND `irq_en`.
- R11: After reset `busy`, `done`, `err`, `irq`, `tag_ce` and `wb_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 invalidate, 1 flush, 2 synchronize, 3 reserved |
| cmd_zone_lo | input | LINE_W | Lowest line address of the zone |
| cmd_zone_hi | input | LINE_W | Highest line address of the zone |
| cmd_task | input | TASK_W | Task identifier to match |
| cmd_burst_log2 | input | BL_W | log2 of fetch sets per write-back request |
| done_clr | input | 1 | Clears `done` |
| err_clr | input | 1 | Clears `err` |
| irq_en | input | 1 | Enables `irq` |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky rejected-command flag |
| irq | output | 1 | Completion interrupt |
| core_lookup | input | 1 | Core owns the tag port this cycle |
| tag_ce | output | 1 | Tag port access strobe |
| tag_we | output | 1 | Tag port write (else read) |
| tag_idx | output | IDX_W | Set index |
| tag_way | output | WAY_W | Way |
| tag_wvalid | output | 1 | Valid bit to write |
| tag_wdirty | output | N_FS | Dirty bits to write |
| tag_rvalid | input | 1 | Read valid bit, one cycle after a read |
| tag_rtag | input | TAG_W | Read address tag |
| tag_rtask | input | TASK_W | Read task field |
| tag_rdirty | input | N_FS | Read dirty bits |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back buffer accepts |
| wb_addr | output | LINE_W+FS_W | Fetch-set address of the group |
| wb_len | output | FS_W+1 | Fetch sets in the group |

## Verification
Two functions can meet in one clock cycle. A sweep can finish in the same cycle that software writes the done-clear, and a core lookup can claim the tag port in the same cycle that the engine wants it for a read or a write-back. To provoke the first, `done_clr` is held high for the whole sweep, so it is certainly present on the completing edge, and `done` must read set afterwards. To provoke the second, `core_lookup` and `wb_ready` are toggled pseudo-randomly during a synchronize sweep. The check is that `tag_ce` never overlaps a lookup, and that the final tag contents and the ordered write-back stream equal those computed without interference.

// File: rtl/zse_pkg.sv
package zse_pkg;
   typedef enum logic [1:0] {
      OP_INVAL = 2'd0,
      OP_FLUSH = 2'd1,
      OP_SYNC  = 2'd2,
      OP_RSVD  = 2'd3
   } zse_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_CHECK = 3'd2,
      ST_WBACK = 3'd3,
      ST_WRITE = 3'd4,
      ST_NEXT  = 3'd5
   } zse_state_e;
endpackage

// File: rtl/zse_cmd_ctrl.sv
module zse_cmd_ctrl
   import zse_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_go,
   input  logic [1:0] cmd_op,
   input  logic       done_clr,
   input  logic       err_clr,
   input  logic       irq_en,
   input  logic       finish,
   output logic       busy,
   output logic       done,
   output logic       err,
   output logic       irq,
   output logic       start
);
   logic busy_q, done_q, err_q, reject;

   assign start  = cmd_go && !busy_q && (cmd_op != OP_RSVD);
   assign reject = cmd_go && !start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (start)       busy_q <= 1'b1;
         else if (finish) busy_q <= 1'b0;
         // completion wins over a simultaneous clear
         if (finish)        done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
         if (reject)        err_q <= 1'b1;
         else if (err_clr)  err_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign err  = err_q;
   assign irq  = done_q & irq_en;

   AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && busy_q |=> err_q && busy_q); // R9
   AST_BAD_OP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_go && !busy_q && cmd_op == OP_RSVD |=> err_q && !busy_q); // R9
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !done_clr |=> done_q); // R8
   AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> done_q && !busy_q); // R8
endmodule

// File: rtl/zse_walker.sv
module zse_walker #(
   parameter int N_SETS = 16,
   parameter int N_WAYS = 8,
   localparam int IDX_W = $clog2(N_SETS),
   localparam int WAY_W = $clog2(N_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output logic [WAY_W-1:0] way,
   output logic             last
);
   localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(N_SETS - 1);
   localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(N_WAYS - 1);

   if (N_SETS < 2) begin : g_bad_sets
      $error("zse_walker: N_SETS must be at least 2");
   end
   if (N_WAYS < 2) begin : g_bad_ways
      $error("zse_walker: N_WAYS must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;
   logic [WAY_W-1:0] way_q;
   logic             way_wrap;

   // a power-of-two way count wraps on its own; other counts compare
   if ((1 << WAY_W) == N_WAYS) begin : g_way_pow2
      assign way_wrap = &way_q;
   end else begin : g_way_cmp
      assign way_wrap = (way_q == WAY_MAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         idx_q <= '0;
         way_q <= '0;
      end else if (step) begin
         if (way_wrap) begin
            way_q <= '0;
            idx_q <= (idx_q == IDX_MAX) ? '0 : idx_q + 1'b1;
         end else begin
            way_q <= way_q + 1'b1;
         end
      end
   end

   assign idx  = idx_q;
   assign way  = way_q;
   assign last = (idx_q == IDX_MAX) && way_wrap;

   AST_WALK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      step && !clear && !way_wrap |=> idx == $past(idx) && way == $past(way) + 1'b1); // R5
endmodule

// File: rtl/zse_chunk_find.sv
module zse_chunk_find #(
   parameter int N_FS = 16,
   parameter int BL_W = 3,
   localparam int FS_W  = $clog2(N_FS),
   localparam int POS_W = FS_W + 1
) (
   input  logic [N_FS-1:0]  dirty,
   input  logic [POS_W-1:0] pos,
   input  logic [BL_W-1:0]  blog,
   output logic             found,
   output logic [FS_W-1:0]  first,
   output logic [POS_W-1:0] size
);
   if ((1 << FS_W) != N_FS) begin : g_bad_fs
      $error("zse_chunk_find: N_FS must be a power of two");
   end
   if ((1 << BL_W) - 1 < FS_W) begin : g_bad_bl
      $error("zse_chunk_find: BL_W too narrow for the line size");
   end

   logic [BL_W-1:0] beff;
   logic [FS_W-1:0] lowest;
   logic [FS_W-1:0] mask;

   assign beff = (blog > BL_W'(FS_W)) ? BL_W'(FS_W) : blog;
   assign size = POS_W'(1) << beff;
   assign mask = FS_W'(size - 1'b1);

   always_comb begin
      found  = 1'b0;
      lowest = '0;
      for (int f = N_FS - 1; f >= 0; f--) begin
         if (dirty[f] && (f >= int'(pos))) begin
            found  = 1'b1;
            lowest = FS_W'(f);
         end
      end
   end

   assign first = lowest & ~mask;
endmodule

// File: rtl/zone_sweep_engine.sv
module zone_sweep_engine
   import zse_pkg::*;
#(
   parameter int N_SETS = 16,
   parameter int N_WAYS = 8,
   parameter int N_FS   = 16,
   parameter int TAG_W  = 12,
   parameter int TASK_W = 8,
   parameter int BL_W   = 3,
   localparam int IDX_W  = $clog2(N_SETS),
   localparam int WAY_W  = $clog2(N_WAYS),
   localparam int FS_W   = $clog2(N_FS),
   localparam int LINE_W = TAG_W + IDX_W,
   localparam int POS_W  = FS_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_go,
   input  logic [1:0]             cmd_op,
   input  logic [LINE_W-1:0]      cmd_zone_lo,
   input  logic [LINE_W-1:0]      cmd_zone_hi,
   input  logic [TASK_W-1:0]      cmd_task,
   input  logic [BL_W-1:0]        cmd_burst_log2,
   input  logic                   done_clr,
   input  logic                   err_clr,
   input  logic                   irq_en,
   output logic                   busy,
   output logic                   done,
   output logic                   err,
   output logic                   irq,
   input  logic                   core_lookup,
   output logic                   tag_ce,
   output logic                   tag_we,
   output logic [IDX_W-1:0]       tag_idx,
   output logic [WAY_W-1:0]       tag_way,
   output logic                   tag_wvalid,
   output logic [N_FS-1:0]        tag_wdirty,
   input  logic                   tag_rvalid,
   input  logic [TAG_W-1:0]       tag_rtag,
   input  logic [TASK_W-1:0]      tag_rtask,
   input  logic [N_FS-1:0]        tag_rdirty,
   output logic                   wb_valid,
   input  logic                   wb_ready,
   output logic [LINE_W+FS_W-1:0] wb_addr,
   output logic [POS_W-1:0]       wb_len
);
   if (TAG_W < 1 || TASK_W < 1) begin : g_bad_fields
      $error("zone_sweep_engine: tag and task widths must be positive");
   end

   zse_state_e        st_q, st_d;
   zse_op_e           op_q;
   logic [LINE_W-1:0] lo_q, hi_q;
   logic [TASK_W-1:0] task_q;
   logic [BL_W-1:0]   blog_q;
   logic [TAG_W-1:0]  tag_q;
   logic [N_FS-1:0]   dirty_q;
   logic [POS_W-1:0]  pos_q;

   logic              start, finish, step, last;
   logic [IDX_W-1:0]  idx;
   logic [WAY_W-1:0]  way;
   logic [LINE_W-1:0] line_rd;
   logic              hit;
   logic              ch_found;
   logic [FS_W-1:0]   ch_first;
   logic [POS_W-1:0]  ch_size;

   zse_cmd_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_go   (cmd_go),
      .cmd_op   (cmd_op),
      .done_clr (done_clr),
      .err_clr  (err_clr),
      .irq_en   (irq_en),
      .finish   (finish),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .irq      (irq),
      .start    (start)
   );

   zse_walker #(.N_SETS(N_SETS), .N_WAYS(N_WAYS)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .step  (step),
      .idx   (idx),
      .way   (way),
      .last  (last)
   );

   zse_chunk_find #(.N_FS(N_FS), .BL_W(BL_W)) u_chunk (
      .dirty (dirty_q),
      .pos   (pos_q),
      .blog  (blog_q),
      .found (ch_found),
      .first (ch_first),
      .size  (ch_size)
   );

   // entry qualification on the registered read data
   assign line_rd = {tag_rtag, idx};
   assign hit     = tag_rvalid && (tag_rtask == task_q) &&
                    (line_rd >= lo_q) && (line_rd <= hi_q);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (start) st_d = ST_READ;
         ST_READ:  if (!core_lookup) st_d = ST_CHECK;
         ST_CHECK: begin
            if (!hit)                  st_d = ST_NEXT;
            else if (op_q == OP_INVAL) st_d = ST_WRITE;
            else if (|tag_rdirty)      st_d = ST_WBACK;
            else if (op_q == OP_FLUSH) st_d = ST_WRITE;
            else                       st_d = ST_NEXT;
         end
         ST_WBACK: if (!ch_found) st_d = ST_WRITE;
         ST_WRITE: if (!core_lookup) st_d = ST_NEXT;
         ST_NEXT:  st_d = last ? ST_IDLE : ST_READ;
         default:  st_d = ST_IDLE;
      endcase
   end

   assign finish = (st_q == ST_NEXT) && last;
   assign step   = (st_q == ST_NEXT) && !last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_INVAL;
         lo_q    <= '0;
         hi_q    <= '0;
         task_q  <= '0;
         blog_q  <= '0;
         tag_q   <= '0;
         dirty_q <= '0;
         pos_q   <= '0;
      end else begin
         st_q <= st_d;
         if (start) begin
            op_q   <= zse_op_e'(cmd_op);
            lo_q   <= cmd_zone_lo;
            hi_q   <= cmd_zone_hi;
            task_q <= cmd_task;
            blog_q <= cmd_burst_log2;
         end
         if (st_q == ST_CHECK) begin
            tag_q   <= tag_rtag;
            dirty_q <= tag_rdirty;
            pos_q   <= '0;
         end else if (st_q == ST_WBACK && ch_found && wb_ready) begin
            pos_q <= POS_W'(ch_first) + ch_size;
         end
      end
   end

   // tag port: yields to the core, retries the same entry
   assign tag_ce     = ((st_q == ST_READ) || (st_q == ST_WRITE)) && !core_lookup;
   assign tag_we     = (st_q == ST_WRITE);
   assign tag_idx    = idx;
   assign tag_way    = way;
   assign tag_wvalid = (op_q == OP_SYNC);
   assign tag_wdirty = '0;

   // write-back request port
   assign wb_valid = (st_q == ST_WBACK) && ch_found;
   assign wb_addr  = {tag_q, idx, ch_first};
   assign wb_len   = ch_size;

   AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (st_q == ST_READ || st_q == ST_WRITE) && core_lookup
      |=> $stable(tag_idx) && $stable(tag_way)); // R7
   AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_len)); // R6
   AST_WB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (wb_addr[FS_W-1:0] & FS_W'(wb_len - 1'b1)) == '0); // R6
   AST_INV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_q == OP_INVAL |-> !wb_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tag_ce && !wb_valid); // R11
   AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy)); // R8
endmodule

// File: tb/sim_zone_sweep_engine.sv
`timescale 1ns/1ps
module sim_zone_sweep_engine;
   localparam int NS = 16, NW = 8, NF = 16, TW = 12, KW = 8, BW = 3;
   localparam int NE = NS * NW;
   localparam int LW = TW + 4;
   localparam int AW = LW + 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cmd_go = 1'b0;
   logic [1:0]    cmd_op = '0;
   logic [LW-1:0] zlo = '0, zhi = '0;
   logic [KW-1:0] ctask = '0;
   logic [BW-1:0] cblog = '0;
   logic          done_clr = 1'b0, err_clr = 1'b0, irq_en = 1'b0;
   logic          busy, done, err, irq;
   logic          core_lookup = 1'b0;
   logic          tag_ce, tag_we, tag_wvalid;
   logic [3:0]    tag_idx;
   logic [2:0]    tag_way;
   logic [NF-1:0] tag_wdirty;
   logic          rd_v = 1'b0;
   logic [TW-1:0] rd_tag = '0;
   logic [KW-1:0] rd_task = '0;
   logic [NF-1:0] rd_dirty = '0;
   logic          wb_valid;
   logic          wb_ready = 1'b1;
   logic [AW-1:0] wb_addr;
   logic [4:0]    wb_len;

   zone_sweep_engine #(.N_SETS(NS), .N_WAYS(NW), .N_FS(NF), .TAG_W(TW),
                       .TASK_W(KW), .BL_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op),
      .cmd_zone_lo(zlo), .cmd_zone_hi(zhi), .cmd_task(ctask),
      .cmd_burst_log2(cblog), .done_clr(done_clr), .err_clr(err_clr),
      .irq_en(irq_en), .busy(busy), .done(done), .err(err), .irq(irq),
      .core_lookup(core_lookup), .tag_ce(tag_ce), .tag_we(tag_we),
      .tag_idx(tag_idx), .tag_way(tag_way), .tag_wvalid(tag_wvalid),
      .tag_wdirty(tag_wdirty), .tag_rvalid(rd_v), .tag_rtag(rd_tag),
      .tag_rtask(rd_task), .tag_rdirty(rd_dirty), .wb_valid(wb_valid),
      .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_len(wb_len));

   int n_chk = 0, n_bad = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // ---------------- tag array model ----------------
   logic          m_valid [NE];
   logic [TW-1:0] m_tag   [NE];
   logic [KW-1:0] m_task  [NE];
   logic [NF-1:0] m_dirty [NE];
   logic          fill_en = 1'b0;
   int            fill_seed = 0;

   function automatic logic [31:0] mix(input int e, input int s);
      logic [31:0] h;
      h = 32'(e) * 32'h9E3779B1 + 32'(s) * 32'h85EBCA6B;
      return h ^ (h >> 13);
   endfunction

   always @(posedge clk) begin
      int ent;
      if (fill_en) begin
         for (int e = 0; e < NE; e++) begin
            m_valid[e] <= ((e * 7 + fill_seed) % 5) != 0;
            m_tag[e]   <= TW'((e * 37 + fill_seed * 11) % 8);
            m_task[e]  <= KW'((e + fill_seed) % 3);
            m_dirty[e] <= (e % 4 == 0) ? '0 : (mix(e, fill_seed)[15:0] & mix(e, fill_seed)[31:16]);
         end
      end else if (tag_ce) begin
         ent = int'(tag_idx) * NW + int'(tag_way);
         if (tag_we) begin
            m_valid[ent] <= tag_wvalid;
            m_dirty[ent] <= tag_wdirty;
         end else begin
            rd_v     <= m_valid[ent];
            rd_tag   <= m_tag[ent];
            rd_task  <= m_task[ent];
            rd_dirty <= m_dirty[ent];
         end
      end
   end

   // ---------------- write-back log ----------------
   logic          log_clr = 1'b0;
   int            n_got = 0;
   logic [AW-1:0] got_addr [2048];
   logic [4:0]    got_len  [2048];

   always @(posedge clk) begin
      if (log_clr) n_got <= 0;
      else if (wb_valid && wb_ready) begin
         got_addr[n_got] <= wb_addr;
         got_len[n_got]  <= wb_len;
         n_got <= n_got + 1;
      end
   end

   // ---------------- interference generator ----------------
   logic        noise_en = 1'b0, stall_en = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int          viol = 0;

   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      core_lookup = noise_en & lfsr[1];
      wb_ready    = stall_en ? (lfsr[5] | lfsr[9]) : 1'b1;
      #1;
      if (tag_ce && core_lookup) viol++;
   end

   // ---------------- expected results ----------------
   logic          x_valid [NE];
   logic [NF-1:0] x_dirty [NE];
   logic [AW-1:0] x_addr  [2048];
   logic [4:0]    x_len   [2048];
   int            n_exp;

   task automatic predict(input int op, input int lo, input int hi,
                          input int tk, input int blog);
      int bl, sz, line;
      bit hitm;
      n_exp = 0;
      bl = (blog > 4) ? 4 : blog;
      sz = 1 << bl;
      for (int e = 0; e < NE; e++) begin
         x_valid[e] = m_valid[e];
         x_dirty[e] = m_dirty[e];
         line = int'(m_tag[e]) * NS + e / NW;
         hitm = m_valid[e] && int'(m_task[e]) == tk && line >= lo && line <= hi;
         if (hitm) begin
            if (op != 0) begin
               for (int c = 0; c < NF; c += sz) begin
                  if (((m_dirty[e] >> c) & NF'((1 << sz) - 1)) != '0) begin
                     x_addr[n_exp] = AW'(line * NF + c);
                     x_len[n_exp]  = 5'(sz);
                     n_exp++;
                  end
               end
            end
            if (op == 0 || op == 1) begin
               x_valid[e] = 1'b0;
               x_dirty[e] = '0;
            end else begin
               x_dirty[e] = '0;
            end
         end
      end
   endtask

   task automatic fill(input int seed);
      @(negedge clk);
      fill_seed = seed;
      fill_en = 1'b1;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic wait_idle(input string rq);
      int t = 0;
      while (busy && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(!busy, rq, "sweep did not finish", busy, 0);
   endtask

   task automatic issue(input int op, input int lo, input int hi,
                        input int tk, input int blog);
      @(negedge clk);
      cmd_go = 1'b1;
      cmd_op = 2'(op);
      zlo = LW'(lo);
      zhi = LW'(hi);
      ctask = KW'(tk);
      cblog = BW'(blog);
      @(negedge clk);
      cmd_go = 1'b0;
   endtask

   task automatic compare(input string rq);
      int bad_tag = 0, bad_wb = 0, first = -1;
      for (int e = 0; e < NE; e++)
         if (m_valid[e] !== x_valid[e] || m_dirty[e] !== x_dirty[e]) begin
            bad_tag++;
            if (first < 0) first = e;
         end
      chk(bad_tag == 0, rq, $sformatf("tag entries wrong, first entry %0d", first),
          bad_tag, 0);
      chk(n_got == n_exp, rq, "write-back request count", n_got, n_exp);
      for (int i = 0; i < n_exp && i < n_got; i++)
         if (got_addr[i] !== x_addr[i] || got_len[i] !== x_len[i]) begin
            if (bad_wb == 0)
               chk(1'b0, rq, $sformatf("write-back #%0d addr/len", i),
                   {got_addr[i], 3'b0, got_len[i]}, {x_addr[i], 3'b0, x_len[i]});
            bad_wb++;
         end
      if (bad_wb == 0) chk(1'b1, rq, "write-back stream", 0, 0);
   endtask

   task automatic run(input int op, input int lo, input int hi, input int tk,
                      input int blog, input string rq);
      predict(op, lo, hi, tk, blog);
      @(negedge clk);
      log_clr = 1'b1;
      done_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      done_clr = 1'b0;
      issue(op, lo, hi, tk, blog);
      chk(busy === 1'b1, "R8", "busy after accepted command", busy, 1);
      wait_idle("R8");
      chk(done === 1'b1, "R8", "done after completion", done, 1);
      compare(rq);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(busy === 0 && done === 0 && err === 0, "R11", "status after reset",
          {busy, done, err}, 0);
      chk(irq === 0 && tag_ce === 0 && wb_valid === 0, "R11", "outputs after reset",
          {irq, tag_ce, wb_valid}, 0);
   endtask

   task automatic t_invalidate;
      fill(1);
      run(0, 'h10, 'h5F, 1, 0, "R1 R4");
   endtask

   task automatic t_flush;
      fill(2);
      stall_en = 1'b1;
      run(1, 'h00, 'h7F, 2, 0, "R2 R5");
      stall_en = 1'b0;
   endtask

   task automatic t_sync_contended;
      fill(3);
      viol = 0;
      noise_en = 1'b1;
      stall_en = 1'b1;
      run(2, 'h20, 'h4F, 0, 2, "R3 R7");
      noise_en = 1'b0;
      stall_en = 1'b0;
      chk(viol == 0, "R7", "tag access during core lookup", viol, 0);
   endtask

   task automatic t_burst_sizes;
      fill(4);
      run(1, 'h00, 'h7F, 1, 7, "R6");
      fill(5);
      run(2, 'h08, 'h77, 2, 1, "R6 R5");
   endtask

   task automatic t_reject;
      fill(6);
      predict(0, 'h00, 'h7F, 0, 0);
      @(negedge clk);
      log_clr = 1'b1;
      err_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      err_clr = 1'b0;
      issue(0, 'h00, 'h7F, 0, 0);
      repeat (5) @(negedge clk);
      issue(1, 'h00, 'h7F, 1, 0);
      chk(err === 1'b1, "R9", "err after command while busy", err, 1);
      wait_idle("R9");
      compare("R9");
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk(err === 1'b0, "R9", "err after clear", err, 0);
      issue(3, 'h00, 'h7F, 0, 0);
      chk(err === 1'b1 && busy === 1'b0, "R9", "reserved op rejected",
          {err, busy}, 2'b10);
   endtask

   task automatic t_done_collision;
      fill(7);
      predict(2, 'h00, 'h7F, 1, 3);
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      done_clr = 1'b1;   // held through the completing edge
      issue(2, 'h00, 'h7F, 1, 3);
      wait_idle("R8");
      done_clr = 1'b0;
      chk(done === 1'b1, "R8", "done when clear meets completion", done, 1);
      compare("R3");
      irq_en = 1'b1;
      #0.5;
      chk(irq === 1'b1, "R10", "irq with done and enable", irq, 1);
      irq_en = 1'b0;
      #0.5;
      chk(irq === 1'b0, "R10", "irq masked", irq, 0);
      @(negedge clk);
      done_clr = 1'b1;
      irq_en = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk(done === 1'b0 && irq === 1'b0, "R10", "done and irq after clear",
          {done, irq}, 0);
      irq_en = 1'b0;
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_invalidate();
      t_flush();
      t_sync_contended();
      t_burst_sizes();
      t_reject();
      t_done_collision();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end
endmodule